// File: doc/BRIEF.md
# Packet Accumulation Wake Controller

This controller runs next to an Ethernet receive path and decides when a sleeping host has to be woken. The host sets three limits and arms sleep. From then on, each received packet arrives as a one-cycle strobe that carries its byte length and a classification flag (bufferable or urgent). The block keeps running totals of packets and bytes held in the accumulation buffer. It raises a wake request under any of these conditions:

- the packet total reaches its limit;
- the free byte space falls below one maximum-size frame of headroom;
- a latency timer, started by the first buffered packet, runs out;
- an urgent packet arrives.

A sticky reason register records which condition or conditions fired. The host acknowledges the wake request, which empties the totals and returns the block to its awake state. The host clears reason bits separately, one bit per write-one. Packets that arrive while the request is pending are still added to the totals. Packet storage, classification and protocol handling are done by other blocks.

Top module: `pkt_accum_wake`

## Requirements
- R1: While the block is awake, a pulse on `arm_sleep` captures `cfg_pkt_limit`, `cfg_byte_limit` and `cfg_timeout` and moves the block to an armed, empty state with both totals at zero. Later changes on the cfg inputs have no effect until the next arm. Packets strobed while awake are not counted.
- R2: While armed, accumulating or waiting for acknowledge, every `rx_valid` adds 1 to `pkt_count` and `rx_len` to `byte_count`. Both totals saturate at their all-ones value.
- R3: A packet that brings `pkt_count` to at least the captured packet limit triggers a wake and sets reason bit 0.
- R4: A packet that leaves `byte_limit - byte_count` below `MARGIN` (default 1518) triggers a wake and sets reason bit 1.
- R5: The latency timer starts only with the first packet after arming, so an armed block that receives no packets never wakes. With a captured timeout T ≥ 1, the timeout wake is raised T cycles after the edge that took the first packet, and reason bit 2 is set. A T of 0 behaves like 1.
- R6: An urgent packet (`rx_urgent`=1 together with `rx_valid`) received while armed or accumulating triggers a wake at once and sets reason bit 3.
- R7: When several wake conditions are true in the same cycle, all of their reason bits are set together.
- R8: `wake_req` stays high until `wake_ack`. Packets received in the meantime are still counted.
- R9: `wake_ack` while `wake_req` is high clears both totals, returns the block to awake and drops `wake_req` on the same edge.
- R10: Reason bits stay set across acknowledge and re-arm. A reason bit is cleared only by a 1 in the matching bit of `reason_clr`. If a set and a clear hit the same bit in the same cycle, the set wins.
- R11: `wake_req` and the reason bits change on the same clock edge that samples the packet or timer expiry that triggered the wake. The reason register is never zero while `wake_req` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm_sleep | input | 1 | Host arms sleep; captures the limits |
| cfg_pkt_limit | input | PKT_W | Packet-count wake limit |
| cfg_byte_limit | input | BYTE_W | Accumulation buffer capacity in bytes |
| cfg_timeout | input | TMR_W | Latency limit in cycles after the first packet |
| rx_valid | input | 1 | One-cycle strobe per received packet |
| rx_len | input | LEN_W | Byte length of the strobed packet |
| rx_urgent | input | 1 | Packet class needs immediate service |
| wake_ack | input | 1 | Host acknowledges the wake request |
| reason_clr | input | 4 | Write-one-to-clear mask for the reason bits |
| wake_req | output | 1 | Wake request to the host |
| wake_reason | output | 4 | Sticky reasons: 0 count, 1 bytes, 2 timeout, 3 urgent |
| pkt_count | output | PKT_W | Packets accumulated |
| byte_count | output | BYTE_W | Bytes accumulated |

## Verification
Every result is one register stage away from its stimulus. The totals, `wake_req` and the reason bits reflect a packet right after the rising edge that samples `rx_valid`. An acknowledge or an arm takes effect on the edge that samples it. A timeout wake appears exactly T edges after the first-packet edge. The bench drives inputs on falling edges and reads outputs on the next falling edge. For the timer, it checks that `wake_req` is still low one cycle before the computed expiry and high at it. The byte sweep computes, for each capacity, which packet index should first break the headroom. It then checks that no earlier packet raised the request.

// File: rtl/pkt_accum_wake_pkg.sv
package pkt_accum_wake_pkg;

   typedef enum logic [1:0] {
      ST_AWAKE = 2'd0,
      ST_ARMED = 2'd1,
      ST_ACCUM = 2'd2,
      ST_WAKE  = 2'd3
   } paw_state_e;

   localparam int RSN_N   = 4;
   localparam int RSN_CNT = 0;
   localparam int RSN_BYT = 1;
   localparam int RSN_TMO = 2;
   localparam int RSN_URG = 3;

endpackage

// File: rtl/paw_sat_accum.sv
// Clearable accumulator; nxt_o is the value the register takes if add_i is applied.
module paw_sat_accum #(
   parameter int W        = 8,
   parameter bit SATURATE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic         add_i,
   input  logic [W-1:0] inc_i,
   output logic [W-1:0] val_o,
   output logic [W-1:0] nxt_o
);
   logic [W-1:0] val_q;
   logic [W:0]   wide_sum;

   assign wide_sum = {1'b0, val_q} + {1'b0, inc_i};

   generate
      if (SATURATE) begin : g_sat
         assign nxt_o = wide_sum[W] ? {W{1'b1}} : wide_sum[W-1:0];
      end else begin : g_wrap
         assign nxt_o = wide_sum[W-1:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     val_q <= '0;
      else if (clr_i) val_q <= '0;
      else if (add_i) val_q <= nxt_o;
   end

   assign val_o = val_q;
endmodule

// File: rtl/paw_latency_timer.sv
// Down-counter loaded at the first packet; expires while running at a count of one or less.
module paw_latency_timer #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic         run_i,
   input  logic [W-1:0] limit_i,
   output logic         expire_o
);
   logic [W-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                left_q <= '0;
      else if (load_i)                           left_q <= limit_i;
      else if (run_i && (left_q > W'(1)))        left_q <= left_q - W'(1);
   end

   assign expire_o = run_i && (left_q <= W'(1));
endmodule

// File: rtl/paw_reason_reg.sv
// Sticky reason flags, write-one-to-clear; a set wins over a clear.
module paw_reason_reg #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] flags_o
);
   logic [N-1:0] flags_q;

   generate
      for (genvar i = 0; i < N; i++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        flags_q[i] <= 1'b0;
            else if (set_i[i]) flags_q[i] <= 1'b1;
            else if (clr_i[i]) flags_q[i] <= 1'b0;
         end
      end
   endgenerate

   assign flags_o = flags_q;
endmodule

// File: rtl/pkt_accum_wake.sv
module pkt_accum_wake
   import pkt_accum_wake_pkg::*;
#(
   parameter int PKT_W    = 8,
   parameter int BYTE_W   = 16,
   parameter int LEN_W    = 11,
   parameter int TMR_W    = 16,
   parameter int MARGIN   = 1518,
   parameter bit SATURATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arm_sleep,
   input  logic [PKT_W-1:0]  cfg_pkt_limit,
   input  logic [BYTE_W-1:0] cfg_byte_limit,
   input  logic [TMR_W-1:0]  cfg_timeout,
   input  logic              rx_valid,
   input  logic [LEN_W-1:0]  rx_len,
   input  logic              rx_urgent,
   input  logic              wake_ack,
   input  logic [3:0]        reason_clr,
   output logic              wake_req,
   output logic [3:0]        wake_reason,
   output logic [PKT_W-1:0]  pkt_count,
   output logic [BYTE_W-1:0] byte_count
);
   localparam int PAD_W = BYTE_W - LEN_W;

   generate
      if (LEN_W >= BYTE_W) begin : g_bad_len
         $fatal(1, "LEN_W must be narrower than BYTE_W");
      end
      if (MARGIN < 1 || MARGIN >= (1 << BYTE_W)) begin : g_bad_margin
         $fatal(1, "MARGIN must fit in BYTE_W bits");
      end
      if (PKT_W < 1 || TMR_W < 1) begin : g_bad_w
         $fatal(1, "counter widths must be positive");
      end
   endgenerate

   paw_state_e        state_q, state_d;
   logic [PKT_W-1:0]  pkt_lim_q;
   logic [BYTE_W-1:0] byte_lim_q;
   logic [TMR_W-1:0]  tmo_q;

   logic              sleeping, arm_take, ack_take, cnt_clr, cnt_add;
   logic [PKT_W-1:0]  pkt_nxt;
   logic [BYTE_W-1:0] byte_nxt;
   logic [BYTE_W:0]   byte_need;
   logic              tmr_load, tmr_run, tmr_exp;
   logic              hit_cnt, hit_byt, hit_tmo, hit_urg, any_hit;
   logic [RSN_N-1:0]  rsn_set;

   assign sleeping = (state_q == ST_ARMED) || (state_q == ST_ACCUM);
   assign arm_take = (state_q == ST_AWAKE) && arm_sleep;
   assign ack_take = (state_q == ST_WAKE) && wake_ack;
   assign cnt_clr  = arm_take || ack_take;
   assign cnt_add  = rx_valid && (state_q != ST_AWAKE);

   // limits captured at arm time
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pkt_lim_q  <= '0;
         byte_lim_q <= '0;
         tmo_q      <= '0;
      end else if (arm_take) begin
         pkt_lim_q  <= cfg_pkt_limit;
         byte_lim_q <= cfg_byte_limit;
         tmo_q      <= cfg_timeout;
      end
   end

   paw_sat_accum #(.W(PKT_W), .SATURATE(SATURATE)) u_pkt_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (cnt_clr),
      .add_i (cnt_add),
      .inc_i (PKT_W'(1)),
      .val_o (pkt_count),
      .nxt_o (pkt_nxt)
   );

   paw_sat_accum #(.W(BYTE_W), .SATURATE(SATURATE)) u_byte_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (cnt_clr),
      .add_i (cnt_add),
      .inc_i ({{PAD_W{1'b0}}, rx_len}),
      .val_o (byte_count),
      .nxt_o (byte_nxt)
   );

   assign tmr_load = (state_q == ST_ARMED) && rx_valid;
   assign tmr_run  = (state_q == ST_ACCUM);

   paw_latency_timer #(.W(TMR_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (tmr_load),
      .run_i    (tmr_run),
      .limit_i  (tmo_q),
      .expire_o (tmr_exp)
   );

   // wake conditions, evaluated on the totals after the current packet
   assign byte_need = {1'b0, byte_nxt} + (BYTE_W+1)'(MARGIN);
   assign hit_cnt   = sleeping && rx_valid && (pkt_nxt >= pkt_lim_q);
   assign hit_byt   = sleeping && rx_valid && (byte_need > {1'b0, byte_lim_q});
   assign hit_urg   = sleeping && rx_valid && rx_urgent;
   assign hit_tmo   = tmr_exp;
   assign any_hit   = hit_cnt || hit_byt || hit_urg || hit_tmo;

   always_comb begin
      rsn_set          = '0;
      rsn_set[RSN_CNT] = hit_cnt;
      rsn_set[RSN_BYT] = hit_byt;
      rsn_set[RSN_TMO] = hit_tmo;
      rsn_set[RSN_URG] = hit_urg;
   end

   paw_reason_reg #(.N(RSN_N)) u_reason (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (rsn_set),
      .clr_i   (reason_clr),
      .flags_o (wake_reason)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_AWAKE: if (arm_sleep) state_d = ST_ARMED;
         ST_ARMED: if (rx_valid)  state_d = any_hit ? ST_WAKE : ST_ACCUM;
         ST_ACCUM: if (any_hit)   state_d = ST_WAKE;
         ST_WAKE:  if (wake_ack)  state_d = ST_AWAKE;
         default:                 state_d = ST_AWAKE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_AWAKE;
      else        state_q <= state_d;
   end

   assign wake_req = (state_q == ST_WAKE);
endmodule

// File: rtl/paw_checker.sv
module paw_checker
   import pkt_accum_wake_pkg::*;
#(
   parameter int PKT_W  = 8,
   parameter int BYTE_W = 16,
   parameter int MARGIN = 1518
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rx_valid,
   input logic              rx_urgent,
   input logic              wake_ack,
   input logic [3:0]        reason_clr,
   input logic              wake_req,
   input logic [3:0]        wake_reason,
   input logic [PKT_W-1:0]  pkt_count,
   input logic [BYTE_W-1:0] byte_count,
   input paw_state_e        state_q,
   input logic [PKT_W-1:0]  pkt_lim_q,
   input logic [BYTE_W-1:0] byte_lim_q
);
   p_armed_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == ST_ARMED |-> (pkt_count == '0) && (byte_count == '0));

   p_cnt_below_r3: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == ST_ACCUM |-> pkt_count < pkt_lim_q);

   p_headroom_r4: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == ST_ACCUM |->
         ({1'b0, byte_count} + (BYTE_W+1)'(MARGIN)) <= {1'b0, byte_lim_q});

   p_urgent_wake_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid && rx_urgent && (state_q == ST_ARMED || state_q == ST_ACCUM)
         |=> wake_req && wake_reason[3]);

   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wake_req && !wake_ack |=> wake_req);

   p_ack_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wake_req && wake_ack |=> !wake_req && (pkt_count == '0) && (byte_count == '0));

   p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((($past(wake_reason) & ~$past(reason_clr)) & ~wake_reason) == 4'b0));

   p_reason_on_wake_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wake_req) |-> wake_reason != 4'b0);
endmodule

bind pkt_accum_wake paw_checker #(
   .PKT_W  (PKT_W),
   .BYTE_W (BYTE_W),
   .MARGIN (MARGIN)
) u_paw_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .rx_valid    (rx_valid),
   .rx_urgent   (rx_urgent),
   .wake_ack    (wake_ack),
   .reason_clr  (reason_clr),
   .wake_req    (wake_req),
   .wake_reason (wake_reason),
   .pkt_count   (pkt_count),
   .byte_count  (byte_count),
   .state_q     (state_q),
   .pkt_lim_q   (pkt_lim_q),
   .byte_lim_q  (byte_lim_q)
);

// File: tb/pkt_accum_wake_bench.sv
module pkt_accum_wake_bench;
   localparam int PW = 4;
   localparam int BW = 13;
   localparam int LW = 11;
   localparam int TW = 5;
   localparam int MG = 1518;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          arm_sleep = 1'b0;
   logic [PW-1:0] cfg_pkt_limit = '0;
   logic [BW-1:0] cfg_byte_limit = '0;
   logic [TW-1:0] cfg_timeout = '0;
   logic          rx_valid = 1'b0;
   logic [LW-1:0] rx_len = '0;
   logic          rx_urgent = 1'b0;
   logic          wake_ack = 1'b0;
   logic [3:0]    reason_clr = '0;
   logic          wake_req;
   logic [3:0]    wake_reason;
   logic [PW-1:0] pkt_count;
   logic [BW-1:0] byte_count;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   pkt_accum_wake #(.PKT_W(PW), .BYTE_W(BW), .LEN_W(LW), .TMR_W(TW), .MARGIN(MG))
   u_pkt_accum_wake (
      .clk(clk), .rst_n(rst_n), .arm_sleep(arm_sleep),
      .cfg_pkt_limit(cfg_pkt_limit), .cfg_byte_limit(cfg_byte_limit),
      .cfg_timeout(cfg_timeout), .rx_valid(rx_valid), .rx_len(rx_len),
      .rx_urgent(rx_urgent), .wake_ack(wake_ack), .reason_clr(reason_clr),
      .wake_req(wake_req), .wake_reason(wake_reason),
      .pkt_count(pkt_count), .byte_count(byte_count)
   );

   task automatic chk(input string tag, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic arm(input int pl, input int bl, input int to);
      cfg_pkt_limit  = pl[PW-1:0];
      cfg_byte_limit = bl[BW-1:0];
      cfg_timeout    = to[TW-1:0];
      arm_sleep = 1'b1;
      @(negedge clk);
      arm_sleep = 1'b0;
   endtask

   task automatic send(input int len, input bit urg);
      rx_valid  = 1'b1;
      rx_len    = len[LW-1:0];
      rx_urgent = urg;
      @(negedge clk);
      rx_valid  = 1'b0;
      rx_urgent = 1'b0;
   endtask

   task automatic ack();
      wake_ack = 1'b1;
      @(negedge clk);
      wake_ack = 1'b0;
   endtask

   task automatic rclr(input logic [3:0] m);
      reason_clr = m;
      @(negedge clk);
      reason_clr = '0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      int caps[8];
      int n_exp;
      caps = '{1518, 1600, 2000, 2018, 2019, 3000, 5000, 8191};
      idle(2);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9 reset wake_req", int'(wake_req), 0);
      chk("R10 reset reasons", int'(wake_reason), 0);
      chk("R2 reset pkt_count", int'(pkt_count), 0);

      // R1: packets while awake are ignored
      send(100, 1'b0); send(100, 1'b1);
      chk("R1 awake pkt ignored", int'(pkt_count), 0);
      chk("R1 awake bytes ignored", int'(byte_count), 0);
      chk("R1 awake no wake", int'(wake_req), 0);

      // R1: limits are captured at arm time only
      arm(2, 8000, 31);
      cfg_pkt_limit = 4'd1;
      send(64, 1'b0);
      chk("R1 captured limit kept", int'(wake_req), 0);
      chk("R2 count 1", int'(pkt_count), 1);
      chk("R2 bytes 64", int'(byte_count), 64);
      send(64, 1'b0);
      chk("R3 wake at captured limit", int'(wake_req), 1);
      ack();
      rclr(4'hF);

      // R3: count-limit sweep
      for (int L = 1; L <= 6; L++) begin
         arm(L, 8000, 31);
         for (int k = 1; k <= L; k++) begin
            send(64, 1'b0);
            chk($sformatf("R3 L=%0d pkt %0d wake", L, k), int'(wake_req), (k == L) ? 1 : 0);
         end
         chk($sformatf("R3 L=%0d reason", L), int'(wake_reason), 1);
         chk($sformatf("R2 L=%0d count", L), int'(pkt_count), L);
         ack();
         chk("R9 ack drops wake", int'(wake_req), 0);
         chk("R9 ack clears count", int'(pkt_count), 0);
         chk("R10 reason kept over ack", int'(wake_reason), 1);
         rclr(4'b0010);
         chk("R10 unrelated clear", int'(wake_reason), 1);
         rclr(4'b0001);
         chk("R10 clear bit0", int'(wake_reason), 0);
      end

      // R4: byte-headroom sweep with 500-byte packets
      foreach (caps[c]) begin
         n_exp = 1;
         while (n_exp * 500 + MG <= caps[c]) n_exp++;
         arm(15, caps[c], 31);
         for (int k = 1; k <= n_exp; k++) begin
            send(500, 1'b0);
            chk($sformatf("R4 cap=%0d pkt %0d wake", caps[c], k), int'(wake_req), (k == n_exp) ? 1 : 0);
         end
         chk($sformatf("R4 cap=%0d reason", caps[c]), int'(wake_reason), 2);
         chk($sformatf("R2 cap=%0d bytes", caps[c]), int'(byte_count), n_exp * 500);
         ack();
         rclr(4'hF);
      end

      // R5: armed with no packets never wakes
      arm(15, 8000, 3);
      idle(40);
      chk("R5 no timer before first pkt", int'(wake_req), 0);
      send(64, 1'b0);
      idle(2);
      chk("R5 T=3 one cycle early", int'(wake_req), 0);
      @(negedge clk);
      chk("R5 T=3 expiry", int'(wake_req), 1);
      ack();
      rclr(4'hF);

      // R5: timeout sweep, T=0 behaves as 1
      for (int T = 0; T <= 8; T++) begin
         int te;
         te = (T == 0) ? 1 : T;
         arm(15, 8000, T);
         send(64, 1'b0);
         idle(te - 1);
         chk($sformatf("R5 T=%0d before", T), int'(wake_req), 0);
         @(negedge clk);
         chk($sformatf("R5 T=%0d at expiry", T), int'(wake_req), 1);
         chk($sformatf("R5 T=%0d reason", T), int'(wake_reason), 4);
         ack();
         rclr(4'hF);
      end

      // R6: urgent first packet, and urgent during accumulation
      arm(15, 8000, 31);
      send(64, 1'b1);
      chk("R6 urgent first wake", int'(wake_req), 1);
      chk("R6 urgent reason", int'(wake_reason), 8);
      ack(); rclr(4'hF);
      arm(15, 8000, 31);
      send(64, 1'b0); send(64, 1'b0);
      chk("R6 still accumulating", int'(wake_req), 0);
      send(64, 1'b1);
      chk("R6 urgent mid wake", int'(wake_req), 1);
      chk("R6 urgent mid reason", int'(wake_reason), 8);
      ack(); rclr(4'hF);

      // R7: simultaneous conditions
      arm(1, 8000, 31);
      send(64, 1'b1);
      chk("R7 count+urgent", int'(wake_reason), 9);
      ack(); rclr(4'hF);
      arm(1, 1518, 31);
      send(64, 1'b0);
      chk("R7 count+bytes", int'(wake_reason), 3);
      ack(); rclr(4'hF);

      // R8 / R2: hold while pending, keep counting, saturate
      arm(1, 8000, 31);
      send(64, 1'b0);
      idle(6);
      chk("R8 held without ack", int'(wake_req), 1);
      send(64, 1'b0); send(64, 1'b0);
      chk("R8 counted while pending", int'(pkt_count), 3);
      chk("R8 bytes while pending", int'(byte_count), 192);
      for (int i = 0; i < 20; i++) send(64, 1'b0);
      chk("R2 count saturates", int'(pkt_count), 15);
      ack();
      chk("R9 ack clears bytes", int'(byte_count), 0);
      chk("R11 reason kept", int'(wake_reason), 1);
      rclr(4'hF);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog R11 actual=hung expected=complete");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule